// File: doc/BRIEF.md
# Conversion Result Averager with Window Detector

This block sits behind a converter and processes raw conversion results. It adds a set number of consecutive valid samples into a wide running sum. When the last sample of a group arrives, it shifts that sum right by a set amount and writes the value into a result register, which gives either a plain average or an oversampled result with more bits. A valid strobe marks each new result.

Each new result is compared against two thresholds. The order of the two thresholds selects the kind of test. If the lower-bound threshold is below the upper-bound threshold, a result strictly between them is a match. If the lower-bound threshold is above the upper-bound threshold, a result strictly outside the pair is a match. Two sticky flags record events: one for each completed result and one for each window match. Each flag has its own interrupt enable. Software can poll the flags, and it clears a flag by pulsing the clear input for that flag.

Top module: `adc_accum_window`

## Requirements
- R1: The group length is set by `cfg_rpt`. Codes 0, 1, 2, 3 and 4 select 1, 4, 8, 16 and 32 samples. Codes 5, 6 and 7 select 64 samples when `cfg_ext` is 1.
- R2: When `cfg_ext` is 0, codes 5, 6 and 7 select 32 samples, so no group is longer than 32 samples.
- R3: The running sum is 20 bits wide. A group of 64 full-scale 14-bit samples (16383 each) gives the exact sum 1048512 with a shift of 0.
- R4: `result` equals the group sum shifted right by `cfg_shift` (0 to 7). `result_valid` is high for one cycle, after the clock edge that takes the last sample. `result` holds its value until the next group completes.
- R5: A cycle with `smp_valid` low adds nothing to the sum and does not advance the group count.
- R6: When `thr_gt` < `thr_lt`, a result matches only if `thr_gt` < result < `thr_lt`. A result equal to either threshold does not match.
- R7: When `thr_gt` > `thr_lt`, a result matches if result > `thr_gt` or result < `thr_lt`. When the two thresholds are equal, no result matches.
- R8: `eoc_flag` is set, and `win_flag` is set on a match, one cycle after the `result_valid` cycle. Each flag stays set until its clear input is high at a clock edge.
- R9: `eoc_irq` is `eoc_flag` gated by `en_eoc`, and `win_irq` is `win_flag` gated by `en_win`. The flags are set whatever the enables are.
- R10: After reset, `result` is 0 and `result_valid`, both flags and both interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Raw sample valid |
| smp_data | input | 14 | Raw sample value |
| cfg_rpt | input | 3 | Group length code |
| cfg_ext | input | 1 | Allow groups of 64 samples |
| cfg_shift | input | 3 | Right shift applied to the sum |
| thr_gt | input | 20 | Greater-than threshold |
| thr_lt | input | 20 | Less-than threshold |
| en_eoc | input | 1 | Interrupt enable for completed results |
| en_win | input | 1 | Interrupt enable for window matches |
| clr_eoc | input | 1 | Clear pulse for the completion flag |
| clr_win | input | 1 | Clear pulse for the window flag |
| result | output | 20 | Shifted result register |
| result_valid | output | 1 | One-cycle new-result strobe |
| eoc_flag | output | 1 | Sticky completion flag |
| win_flag | output | 1 | Sticky window-match flag |
| eoc_irq | output | 1 | Gated completion interrupt |
| win_irq | output | 1 | Gated window interrupt |

## Verification
The assertions check the following on every cycle:
- the result register does not change between strobes;
- each strobe is followed by the completion flag;
- a flag stays set until its clear input is seen;
- each threshold ordering, inside and outside, sets the window flag one cycle after a matching result;
- the window flag is never set without a result;
- no interrupt is raised without its flag.

Other behaviour can only be shown by the bench scenarios:
- the mapping from group-length code to sample count, including the 32-sample cap when the extension is off;
- the exact shifted arithmetic at full scale;
- gaps in the sample stream;
- the strict boundaries, where a result equal to a threshold does not match;
- equal thresholds.

// File: rtl/adc_pp_pkg.sv
package adc_pp_pkg;
    localparam int SMP_W  = 14;
    localparam int ACC_W  = 20;
    localparam int CNT_W  = 7;
    localparam int NFLAG  = 2;
    localparam int FLG_EOC = 0;
    localparam int FLG_WIN = 1;

    typedef enum logic [1:0] {
        WIN_INSIDE  = 2'd0,
        WIN_OUTSIDE = 2'd1,
        WIN_NONE    = 2'd2
    } win_mode_e;

    // Group length from the repeat code; long codes depend on the extension bit.
    function automatic logic [CNT_W-1:0] group_len(input logic [2:0] code, input logic ext);
        case (code)
            3'd0:    group_len = CNT_W'(1);
            3'd1:    group_len = CNT_W'(4);
            3'd2:    group_len = CNT_W'(8);
            3'd3:    group_len = CNT_W'(16);
            3'd4:    group_len = CNT_W'(32);
            default: group_len = ext ? CNT_W'(64) : CNT_W'(32);
        endcase
    endfunction
endpackage

// File: rtl/adc_pp_accum.sv
module adc_pp_accum
    import adc_pp_pkg::*;
#(
    parameter int SW = SMP_W,
    parameter int AW = ACC_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_valid,
    input  logic [SW-1:0] smp_data,
    input  logic [2:0]    cfg_rpt,
    input  logic          cfg_ext,
    input  logic [2:0]    cfg_shift,
    output logic [AW-1:0] res_q,
    output logic          res_vld_q
);
    logic [AW-1:0] acc_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] sum;
    logic [CW-1:0] target;
    logic          last;

    always_comb begin
        sum    = acc_q + AW'(smp_data);
        target = group_len(cfg_rpt, cfg_ext);
        last   = (cnt_q + CW'(1)) >= target;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            cnt_q     <= '0;
            res_q     <= '0;
            res_vld_q <= 1'b0;
        end else begin
            res_vld_q <= 1'b0;
            if (smp_valid) begin
                if (last) begin
                    res_q     <= sum >> cfg_shift;
                    acc_q     <= '0;
                    cnt_q     <= '0;
                    res_vld_q <= 1'b1;
                end else begin
                    acc_q <= sum;
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/adc_pp_window.sv
module adc_pp_window
    import adc_pp_pkg::*;
#(
    parameter int AW = ACC_W
) (
    input  logic [AW-1:0] res,
    input  logic          res_vld,
    input  logic [AW-1:0] thr_gt,
    input  logic [AW-1:0] thr_lt,
    output logic          hit
);
    win_mode_e mode;
    logic      above;
    logic      below;

    always_comb begin
        if (thr_gt < thr_lt)      mode = WIN_INSIDE;
        else if (thr_gt > thr_lt) mode = WIN_OUTSIDE;
        else                      mode = WIN_NONE;
        above = res > thr_gt;
        below = res < thr_lt;
        case (mode)
            WIN_INSIDE:  hit = res_vld && above && below;
            WIN_OUTSIDE: hit = res_vld && (above || below);
            default:     hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/adc_pp_flags.sv
module adc_pp_flags
    import adc_pp_pkg::*;
#(
    parameter int NF = NFLAG
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    input  logic [NF-1:0] en,
    output logic [NF-1:0] flag_q,
    output logic [NF-1:0] irq
);
    for (genvar i = 0; i < NF; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         flag_q[i] <= 1'b0;
            else if (set[i]) flag_q[i] <= 1'b1;
            else if (clr[i]) flag_q[i] <= 1'b0;
        end
        assign irq[i] = flag_q[i] & en[i];
    end
endmodule

// File: rtl/adc_accum_window.sv
module adc_accum_window
    import adc_pp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic [2:0]       cfg_rpt,
    input  logic             cfg_ext,
    input  logic [2:0]       cfg_shift,
    input  logic [ACC_W-1:0] thr_gt,
    input  logic [ACC_W-1:0] thr_lt,
    input  logic             en_eoc,
    input  logic             en_win,
    input  logic             clr_eoc,
    input  logic             clr_win,
    output logic [ACC_W-1:0] result,
    output logic             result_valid,
    output logic             eoc_flag,
    output logic             win_flag,
    output logic             eoc_irq,
    output logic             win_irq
);
    logic             win_hit;
    logic [NFLAG-1:0] f_set, f_clr, f_en, f_q, f_irq;

    adc_pp_accum u_acc (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .cfg_rpt(cfg_rpt), .cfg_ext(cfg_ext), .cfg_shift(cfg_shift),
        .res_q(result), .res_vld_q(result_valid)
    );

    adc_pp_window u_win (
        .res(result), .res_vld(result_valid),
        .thr_gt(thr_gt), .thr_lt(thr_lt), .hit(win_hit)
    );

    always_comb begin
        f_set[FLG_EOC] = result_valid;
        f_set[FLG_WIN] = win_hit;
        f_clr[FLG_EOC] = clr_eoc;
        f_clr[FLG_WIN] = clr_win;
        f_en[FLG_EOC]  = en_eoc;
        f_en[FLG_WIN]  = en_win;
    end

    adc_pp_flags u_flg (
        .clk(clk), .rst(rst), .set(f_set), .clr(f_clr), .en(f_en),
        .flag_q(f_q), .irq(f_irq)
    );

    assign eoc_flag = f_q[FLG_EOC];
    assign win_flag = f_q[FLG_WIN];
    assign eoc_irq  = f_irq[FLG_EOC];
    assign win_irq  = f_irq[FLG_WIN];
endmodule

// File: rtl/adc_pp_checker.sv
module adc_pp_checker
    import adc_pp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clr_eoc,
    input logic             clr_win,
    input logic [ACC_W-1:0] thr_gt,
    input logic [ACC_W-1:0] thr_lt,
    input logic [ACC_W-1:0] result,
    input logic             result_valid,
    input logic             eoc_flag,
    input logic             win_flag,
    input logic             eoc_irq,
    input logic             win_irq
);
    assert_result_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> $stable(result));

    assert_eoc_after_valid_R8: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> eoc_flag);

    assert_eoc_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        eoc_flag && !clr_eoc |=> eoc_flag);

    assert_win_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        win_flag && !clr_win |=> win_flag);

    assert_inside_hit_R6: assert property (@(posedge clk) disable iff (rst)
        result_valid && (thr_gt < thr_lt) && (result > thr_gt) && (result < thr_lt) |=> win_flag);

    assert_outside_hit_R7: assert property (@(posedge clk) disable iff (rst)
        result_valid && (thr_gt > thr_lt) && ((result > thr_gt) || (result < thr_lt)) |=> win_flag);

    assert_no_spurious_win_R7: assert property (@(posedge clk) disable iff (rst)
        !win_flag && !result_valid |=> !win_flag);

    assert_eoc_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
        eoc_irq |-> eoc_flag);

    assert_win_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
        win_irq |-> win_flag);
endmodule

bind adc_accum_window adc_pp_checker u_chk (.*);

// File: tb/tb_adc_accum_window.sv
module tb_adc_accum_window;
    logic        clk = 1'b0;
    logic        rst;
    logic        smp_valid;
    logic [13:0] smp_data;
    logic [2:0]  cfg_rpt, cfg_shift;
    logic        cfg_ext;
    logic [19:0] thr_gt, thr_lt;
    logic        en_eoc, en_win, clr_eoc, clr_win;
    logic [19:0] result;
    logic        result_valid, eoc_flag, win_flag, eoc_irq, win_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct { int res; bit win; bit ee; bit ew; string tag; } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    adc_accum_window dut (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_len(input int code, input bit ext);
        if (code < 5) return (code == 0) ? 1 : (2 << code);
        return ext ? 64 : 32;
    endfunction

    function automatic bit model_win(input int r, input int gt, input int lt);
        if (gt < lt) return (r > gt) && (r < lt);
        if (gt > lt) return (r > gt) || (r < lt);
        return 1'b0;
    endfunction

    task automatic burst(input int code, input bit ext, input int shf, input int base,
                         input int step, input bit gap, input int gt, input int lt,
                         input bit ee, input bit ew, input string tag);
        int n, sum;
        exp_t e;
        n = model_len(code, ext);
        sum = 0;
        for (int i = 0; i < n; i++) sum += base + i * step;
        e.res = sum >>> shf;
        e.win = model_win(e.res, gt, lt);
        e.ee = ee; e.ew = ew; e.tag = tag;
        @(negedge clk);
        cfg_rpt = 3'(code); cfg_ext = ext; cfg_shift = 3'(shf);
        thr_gt = 20'(gt); thr_lt = 20'(lt); en_eoc = ee; en_win = ew;
        sb.push_back(e);
        for (int i = 0; i < n; i++) begin
            smp_valid = 1'b1;
            smp_data  = 14'(base + i * step);
            @(negedge clk);
            if (gap) begin
                smp_valid = 1'b0;
                smp_data  = 14'h3FFF;
                @(negedge clk);
            end
        end
        smp_valid = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    // Monitor: pops one expectation per result strobe
    initial begin
        exp_t e;
        int held;
        forever begin
            @(negedge clk);
            if (result_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R4 unexpected result", int'(result), -1);
                end else begin
                    e = sb.pop_front();
                    check(int'(result) == e.res, {e.tag, " R4 result"}, int'(result), e.res);
                    held = int'(result);
                    @(negedge clk);
                    check(eoc_flag == 1'b1, {e.tag, " R8 eoc set"}, eoc_flag, 1);
                    check(win_flag == e.win, {e.tag, " R8 win flag"}, win_flag, e.win);
                    check(eoc_irq == e.ee, {e.tag, " R9 eoc irq"}, eoc_irq, e.ee);
                    check(win_irq == (e.win & e.ew), {e.tag, " R9 win irq"}, win_irq, e.win & e.ew);
                    @(negedge clk);
                    check(eoc_flag == 1'b1 && win_flag == e.win, {e.tag, " R8 sticky"},
                          {eoc_flag, win_flag}, {1'b1, e.win});
                    clr_eoc = 1'b1; clr_win = 1'b1;
                    @(negedge clk);
                    clr_eoc = 1'b0; clr_win = 1'b0;
                    check(!eoc_flag && !win_flag, {e.tag, " R8 cleared"}, {eoc_flag, win_flag}, 0);
                    check(int'(result) == held && !result_valid, {e.tag, " R4 held"}, int'(result), held);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; smp_valid = 1'b0; smp_data = '0;
        cfg_rpt = '0; cfg_ext = 1'b0; cfg_shift = '0;
        thr_gt = '0; thr_lt = '0; en_eoc = 1'b0; en_win = 1'b0;
        clr_eoc = 1'b0; clr_win = 1'b0;
        repeat (3) @(negedge clk);
        check(result == 0 && !result_valid, "R10 reset result", int'(result), 0);
        check(!eoc_flag && !win_flag && !eoc_irq && !win_irq, "R10 reset flags",
              {eoc_flag, win_flag, eoc_irq, win_irq}, 0);
        rst = 1'b0;
        @(negedge clk);

        burst(0, 0, 0, 1000, 0, 0, 500, 2000, 1, 1, "R1 R6 single inside");
        burst(1, 0, 2, 100, 4, 0, 106, 200, 1, 1, "R1 R6 four at gt edge");
        burst(2, 0, 3, 2000, 0, 1, 0, 2000, 1, 1, "R5 R6 gaps at lt edge");
        burst(5, 0, 0, 10, 1, 0, 3000, 900, 1, 1, "R2 R7 cap32 below");
        burst(5, 1, 0, 16383, 0, 0, 1000, 10, 1, 0, "R3 R9 full64 above");
        burst(7, 1, 6, 16383, 0, 0, 5, 5, 1, 1, "R1 R7 code7 equal thr");
        burst(6, 0, 5, 200, 0, 0, 300, 100, 1, 1, "R2 R7 code6 between");
        burst(3, 0, 4, 0, 2, 0, 10, 20, 0, 1, "R4 R9 sixteen inside");
        burst(4, 0, 7, 16383, 0, 1, 4094, 4096, 1, 1, "R1 R4 R5 shift7");

        repeat (10) @(negedge clk);
        check(sb.size() == 0, "R4 all results seen", sb.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule